// File: doc/BRIEF.md
# Addressable Scan-Port Shadow Controller

This block lets many boards hang on one shared, multidrop test bus built on the IEEE 1149.1 TAP signals. It runs on the primary test clock and keeps its own copy of the TAP controller state by following primary TMS. A board is selected by an address carried in-band on primary TDI. This happens only while the TAP rests in a state that it can hold indefinitely and that is not a shift state. The address is compared with a parallel board address and with three reserved global addresses.

Each address bit travels as two TDI samples on consecutive rising TCK edges: `01` carries a 0 and `10` carries a 1. A `11` pair opens a frame, and address bits follow MSB first. A frame ends after ten valid pairs. A `00` pair, or any TMS value that moves the TAP out of its resting state, abandons the frame. When the board address matches, the block echoes its own address on an acknowledge data line, using the same pair code on falling TCK edges with an enable. It then reports itself connected.

The global addresses are all-ones (disconnect), all-ones minus one (reset) and all-ones minus two (test-sync). The test-sync address selects a listen-only multicast connection and takes effect only in Pause-DR or Pause-IR. A low bypass input makes the block ignore all frames.

Top module: `tap_shadow_port`

## Requirements
- R1: After power-up or while `trst_n_i` is low, `link_o` reads 2'b00 (reset condition) and `ack_oe_o` is 0. Asserting `trst_n_i` low returns any other status to 2'b00.
- R2: Frames are accepted only in Test-Logic-Reset, Run-Test/Idle, Pause-DR and Pause-IR. A complete frame sent while the TAP sits in Shift-DR has no effect on `link_o` and produces no acknowledgment.
- R3: A frame is a `11` start pair followed by ten pairs sampled on rising TCK, with `10` = 1 and `01` = 0, MSB first.
- R4: If the received address equals `brd_addr_i`, `ack_oe_o` is high for exactly 20 consecutive clocks. During that time `ack_tdo_o`, updated on falling edges, carries the board address MSB first with each bit b sent as b then ~b. After the echo, `link_o` becomes 2'b10 (ON).
- R5: A received address that matches neither the board address nor a global address sets `link_o` to 2'b01 (OFF) with no acknowledgment.
- R6: Address 0x3FF sets `link_o` to 2'b01 (OFF) with no acknowledgment.
- R7: Address 0x3FE sets `link_o` to 2'b00 (reset condition).
- R8: Address 0x3FD sets `link_o` to 2'b11 (MULTICAST) only if received in Pause-DR or Pause-IR. In Run-Test/Idle it leaves `link_o` unchanged.
- R9: While `byp_n_i` is low, a complete frame leaves `link_o` unchanged and starts no acknowledgment.
- R10: A `00` pair in mid-frame, or a TMS value that moves the TAP away from its resting state in mid-frame, abandons the frame so that `link_o` does not change.
- R11: A board address equal to a global address acts only as that global command. With `brd_addr_i` = 0x3FF, receiving 0x3FF gives OFF with no acknowledgment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Primary test clock |
| trst_n_i | input | 1 | Primary test reset, active low, asynchronous |
| tms_i | input | 1 | Primary test mode select |
| tdi_i | input | 1 | Primary test data in, carries frames |
| brd_addr_i | input | 10 | Parallel board address |
| byp_n_i | input | 1 | Bypass; low ignores frames |
| ack_tdo_o | output | 1 | Acknowledge serial data, falling-edge timed |
| ack_oe_o | output | 1 | Acknowledge drive enable |
| link_o | output | 2 | Status: 00 reset, 01 OFF, 10 ON, 11 MULTICAST |

## Verification
The hardest situation to reach is a complete, well-formed frame that must be refused because of where the TAP rests. Examples are a test-sync frame in Run-Test/Idle, or a matching frame in Shift-DR. Reaching these takes exact TMS walks through the TAP graph while TDI carries the pair code. The bench drives those walks step by step: from Test-Logic-Reset through Select, Capture and Exit into Pause-DR, and through Update back to Run-Test/Idle. It sends frames at each stop, so the state gating, the abandon paths and the multicast condition are each reached with a known prior status.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  typedef enum logic [3:0] {
    TS_TLR, TS_RTI, TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR,
    TS_UPD_DR, TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_st_e;

  typedef enum logic [1:0] {
    LNK_RESET = 2'b00,
    LNK_OFF   = 2'b01,
    LNK_ON    = 2'b10,
    LNK_MCAST = 2'b11
  } link_e;

  function automatic tap_st_e tap_step(input tap_st_e st, input logic tms);
    tap_st_e nx;
    case (st)
      TS_TLR:    nx = tms ? TS_TLR    : TS_RTI;
      TS_RTI:    nx = tms ? TS_SEL_DR : TS_RTI;
      TS_SEL_DR: nx = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nx = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: nx = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: nx = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nx = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nx = tms ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: nx = tms ? TS_SEL_DR : TS_RTI;
      TS_SEL_IR: nx = tms ? TS_TLR    : TS_CAP_IR;
      TS_CAP_IR: nx = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: nx = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: nx = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nx = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nx = tms ? TS_UPD_IR : TS_SHF_IR;
      TS_UPD_IR: nx = tms ? TS_SEL_DR : TS_RTI;
      default:   nx = TS_TLR;
    endcase
    return nx;
  endfunction

  function automatic logic is_rest_state(input tap_st_e st);
    return (st == TS_TLR) || (st == TS_RTI) || (st == TS_PAU_DR) || (st == TS_PAU_IR);
  endfunction

  function automatic logic is_pause(input tap_st_e st);
    return (st == TS_PAU_DR) || (st == TS_PAU_IR);
  endfunction

endpackage

// File: rtl/tap_tracker.sv
module tap_tracker
  import scan_port_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_n_i,
  input  logic    tms_i,
  output tap_st_e state_o,
  output logic    hold_o
);

  tap_st_e st_q, st_d;

  always_comb begin
    st_d = tap_step(st_q, tms_i);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) st_q <= TS_TLR;
    else          st_q <= st_d;
  end

  // Resting in a frame-capable state and staying there across this edge
  assign hold_o  = is_rest_state(st_q) && (st_d == st_q);
  assign state_o = st_q;

endmodule

// File: rtl/pair_rx.sv
module pair_rx #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              en_i,
  input  logic              tdi_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o
);

  localparam int CNT_W = $clog2(ADDR_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_W - 1);

  typedef enum logic [1:0] {RX_HUNT, RX_FIRST, RX_SECOND} rx_mode_e;

  rx_mode_e          mode_q, mode_d;
  logic              prev_q, prev_d;
  logic              half_q, half_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] sh_q, sh_d;
  logic              done_q, done_d;

  always_comb begin
    mode_d = mode_q;
    prev_d = prev_q;
    half_d = half_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    if (!en_i) begin
      mode_d = RX_HUNT;
      prev_d = 1'b0;
    end else begin
      case (mode_q)
        RX_HUNT: begin
          if (prev_q && tdi_i) begin
            mode_d = RX_FIRST;
            cnt_d  = '0;
            prev_d = 1'b0;
          end else begin
            prev_d = tdi_i;
          end
        end
        RX_FIRST: begin
          half_d = tdi_i;
          mode_d = RX_SECOND;
        end
        RX_SECOND: begin
          case ({half_q, tdi_i})
            2'b10, 2'b01: begin
              sh_d  = {sh_q[ADDR_W-2:0], half_q};
              cnt_d = cnt_q + 1'b1;
              if (cnt_q == LAST_BIT) begin
                done_d = 1'b1;
                mode_d = RX_HUNT;
                prev_d = 1'b0;
              end else begin
                mode_d = RX_FIRST;
              end
            end
            2'b11: begin
              mode_d = RX_FIRST;
              cnt_d  = '0;
            end
            default: begin
              mode_d = RX_HUNT;
              prev_d = 1'b0;
            end
          endcase
        end
        default: begin
          mode_d = RX_HUNT;
          prev_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mode_q <= RX_HUNT;
      prev_q <= 1'b0;
      half_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      prev_q <= prev_d;
      half_q <= half_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign addr_o = sh_q;
  assign busy_o = (mode_q != RX_HUNT);

  // R3: a frame spans twenty-two samples, so completion never repeats on the next edge
  // R3
  frame_done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_q |=> !done_q);

endmodule

// File: rtl/ack_tx.sv
module ack_tx #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              tdo_o,
  output logic              oe_o
);

  localparam int SYM_N = 2 * ADDR_W;
  localparam int CNT_W = $clog2(SYM_N);
  localparam logic [CNT_W-1:0] LAST_SYM = CNT_W'(SYM_N - 1);

  logic [SYM_N-1:0] code;
  logic [SYM_N-1:0] sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             oe_q, oe_d;
  logic             tdo_q, tdo_d;

  // Each address bit b becomes the symbol pair (b, ~b), highest bit first
  for (genvar i = 0; i < ADDR_W; i++) begin : g_code
    assign code[2*i+1] = addr_i[i];
    assign code[2*i]   = ~addr_i[i];
  end

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    oe_d  = oe_q;
    tdo_d = tdo_q;
    if (go_i && !oe_q) begin
      tdo_d = code[SYM_N-1];
      sh_d  = {code[SYM_N-2:0], 1'b0};
      cnt_d = LAST_SYM;
      oe_d  = 1'b1;
    end else if (oe_q) begin
      if (cnt_q == '0) begin
        oe_d  = 1'b0;
        tdo_d = 1'b0;
      end else begin
        tdo_d = sh_q[SYM_N-1];
        sh_d  = {sh_q[SYM_N-2:0], 1'b0};
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(negedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
      oe_q  <= 1'b0;
      tdo_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      oe_q  <= oe_d;
      tdo_q <= tdo_d;
    end
  end

  assign tdo_o = tdo_q;
  assign oe_o  = oe_q;

endmodule

// File: rtl/tap_shadow_port.sv
module tap_shadow_port
  import scan_port_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              tck_i,
  input  logic              trst_n_i,
  input  logic              tms_i,
  input  logic              tdi_i,
  input  logic [ADDR_W-1:0] brd_addr_i,
  input  logic              byp_n_i,
  output logic              ack_tdo_o,
  output logic              ack_oe_o,
  output logic [1:0]        link_o
);

  localparam logic [ADDR_W-1:0] ADR_DISC = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] ADR_RST  = ADR_DISC - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_SYNC = ADR_DISC - ADDR_W'(2);

  // Reset: asserted at once, released on the second rising edge
  logic [1:0] rs_q;
  logic       rst_n;

  always_ff @(posedge tck_i or negedge trst_n_i) begin
    if (!trst_n_i) rs_q <= 2'b00;
    else           rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  tap_st_e           tap_st;
  logic              tap_hold;
  logic              rx_en, rx_done, rx_busy;
  logic [ADDR_W-1:0] rx_addr;
  logic              tx_oe, tx_tdo;

  link_e link_q, link_d;
  logic  wait_q, wait_d;
  logic  go_q, go_d;

  tap_tracker u_tap (
    .clk_i   (tck_i),
    .rst_n_i (rst_n),
    .tms_i   (tms_i),
    .state_o (tap_st),
    .hold_o  (tap_hold)
  );

  assign rx_en = byp_n_i && tap_hold && !wait_q;

  pair_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk_i   (tck_i),
    .rst_n_i (rst_n),
    .en_i    (rx_en),
    .tdi_i   (tdi_i),
    .done_o  (rx_done),
    .addr_o  (rx_addr),
    .busy_o  (rx_busy)
  );

  ack_tx #(.ADDR_W(ADDR_W)) u_tx (
    .clk_i   (tck_i),
    .rst_n_i (rst_n),
    .go_i    (go_q),
    .addr_i  (brd_addr_i),
    .tdo_o   (tx_tdo),
    .oe_o    (tx_oe)
  );

  // Command decode: globals win over the board address
  always_comb begin
    link_d = link_q;
    wait_d = wait_q;
    go_d   = 1'b0;
    if (wait_q) begin
      if (!go_q && !tx_oe) begin
        wait_d = 1'b0;
        link_d = LNK_ON;
      end
    end else if (rx_done && byp_n_i) begin
      if (rx_addr == ADR_DISC) begin
        link_d = LNK_OFF;
      end else if (rx_addr == ADR_RST) begin
        link_d = LNK_RESET;
      end else if (rx_addr == ADR_SYNC) begin
        if (is_pause(tap_st)) link_d = LNK_MCAST;
      end else if (rx_addr == brd_addr_i) begin
        go_d   = 1'b1;
        wait_d = 1'b1;
      end else begin
        link_d = LNK_OFF;
      end
    end
  end

  always_ff @(posedge tck_i or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= LNK_RESET;
      wait_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      link_q <= link_d;
      wait_q <= wait_d;
      go_q   <= go_d;
    end
  end

  assign link_o    = link_q;
  assign ack_oe_o  = tx_oe;
  assign ack_tdo_o = tx_tdo;

  // R4
  ack_only_when_pending_chk: assert property (@(posedge tck_i) disable iff (!rst_n)
    tx_oe |-> wait_q);

  // R8
  mcast_from_pause_chk: assert property (@(posedge tck_i) disable iff (!rst_n)
    (link_q == LNK_MCAST && $past(link_q) != LNK_MCAST) |-> is_pause($past(tap_st)));

  // R9
  bypass_blocks_ack_chk: assert property (@(posedge tck_i) disable iff (!rst_n)
    !byp_n_i |=> !go_q);

  // R2
  no_frame_in_shift_chk: assert property (@(posedge tck_i) disable iff (!rst_n)
    (tap_st == TS_SHF_DR || tap_st == TS_SHF_IR) |-> !rx_busy);

endmodule

// File: tb/tap_shadow_port_tb_top.sv
module tap_shadow_port_tb_top;

  logic       ck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic [9:0] brd = 10'h2A5;
  logic       byp_n = 1'b1;
  logic       tdo, oe;
  logic [1:0] link;

  int total = 0;
  int bad = 0;
  int ack_n = 0;
  logic [39:0] ack_bits;

  always #5 ck = ~ck;

  tap_shadow_port dut_i (
    .tck_i(ck), .trst_n_i(trst_n), .tms_i(tms), .tdi_i(tdi),
    .brd_addr_i(brd), .byp_n_i(byp_n),
    .ack_tdo_o(tdo), .ack_oe_o(oe), .link_o(link)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One TCK: drive after the falling edge, sample the acknowledge pins later
  task automatic step(input logic t, input logic d);
    @(negedge ck);
    #1 tms = t; tdi = d;
    #2;
    if (oe === 1'b1) begin
      if (ack_n < 40) ack_bits[39 - ack_n] = tdo;
      ack_n++;
    end
  endtask

  task automatic idle(input logic t, input int n);
    for (int i = 0; i < n; i++) step(t, 1'b0);
  endtask

  task automatic send_frame(input logic t, input logic [9:0] a);
    ack_n = 0;
    idle(t, 2);
    step(t, 1'b1); step(t, 1'b1);
    for (int i = 9; i >= 0; i--) begin
      step(t, a[i]); step(t, ~a[i]);
    end
  endtask

  task automatic check_no_ack(input string req);
    check(ack_n == 0, req, ack_n, 0);
  endtask

  task automatic t_reset;
    trst_n = 1'b0;
    #23;
    check(link == 2'b00, "R1 reset status", link, 0);
    check(oe == 1'b0, "R1 reset ack enable", oe, 0);
    trst_n = 1'b1;
    idle(1'b1, 6);
    check(link == 2'b00, "R1 status after release", link, 0);
  endtask

  task automatic t_mismatch_tlr;
    send_frame(1'b1, 10'h155);
    idle(1'b1, 4);
    check(link == 2'b01, "R5 mismatch gives OFF in TLR", link, 1);
    check_no_ack("R5 no ack on mismatch");
  endtask

  task automatic t_match(input logic t);
    logic [19:0] exp;
    for (int i = 0; i < 10; i++) begin
      exp[2*i+1] = brd[i];
      exp[2*i]   = ~brd[i];
    end
    send_frame(t, brd);
    idle(t, 30);
    check(ack_n == 20, "R4 ack enable length", ack_n, 20);
    check(ack_bits[39:20] == exp, "R3 R4 ack echo bits", ack_bits[39:20], exp);
    check(link == 2'b10, "R4 ON after echo", link, 2);
  endtask

  task automatic t_sync_rti;
    send_frame(1'b0, 10'h3FD);
    idle(1'b0, 4);
    check(link == 2'b10, "R8 test-sync ignored in RTI", link, 2);
  endtask

  task automatic go_pause_dr;
    step(1'b1, 0); step(1'b0, 0); step(1'b0, 0); step(1'b1, 0); step(1'b0, 0);
  endtask

  task automatic t_sync_pause;
    go_pause_dr();
    send_frame(1'b0, 10'h3FD);
    idle(1'b0, 4);
    check(link == 2'b11, "R8 test-sync in Pause-DR gives MULTICAST", link, 3);
  endtask

  task automatic t_bypass;
    byp_n = 1'b0;
    send_frame(1'b0, 10'h3FF);
    idle(1'b0, 4);
    check(link == 2'b11, "R9 frame ignored in bypass", link, 3);
    send_frame(1'b0, brd);
    idle(1'b0, 30);
    check_no_ack("R9 no ack in bypass");
    check(link == 2'b11, "R9 match ignored in bypass", link, 3);
    byp_n = 1'b1;
  endtask

  task automatic t_abort;
    ack_n = 0;
    idle(1'b0, 2);
    step(1'b0, 1); step(1'b0, 1);
    step(1'b0, 1); step(1'b0, 0);
    step(1'b0, 1); step(1'b0, 0);
    step(1'b0, 0); step(1'b0, 0);
    idle(1'b0, 30);
    check(link == 2'b11, "R10 00 pair abandons frame", link, 3);
    check_no_ack("R10 no ack after 00 abort");
    // TMS leaves Pause-DR mid-frame: Exit2, Update, RTI
    idle(1'b0, 2);
    step(1'b0, 1); step(1'b0, 1);
    step(1'b0, 1); step(1'b0, 1);
    step(1'b1, 0); step(1'b1, 0); step(1'b0, 0);
    idle(1'b0, 30);
    check(link == 2'b11, "R10 TMS move abandons frame", link, 3);
  endtask

  task automatic t_shift;
    step(1'b1, 0); step(1'b0, 0); step(1'b0, 0);
    send_frame(1'b0, brd);
    idle(1'b0, 30);
    check_no_ack("R2 no ack in Shift-DR");
    check(link == 2'b11, "R2 frame ignored in Shift-DR", link, 3);
    step(1'b1, 0); step(1'b0, 0);
  endtask

  task automatic t_globals;
    send_frame(1'b0, 10'h3FF);
    idle(1'b0, 4);
    check(link == 2'b01, "R6 disconnect gives OFF", link, 1);
    check_no_ack("R6 no ack on disconnect");
    send_frame(1'b0, 10'h3FE);
    idle(1'b0, 4);
    check(link == 2'b00, "R7 reset address gives reset condition", link, 0);
  endtask

  task automatic t_global_board;
    step(1'b1, 0); step(1'b1, 0); step(1'b0, 0);
    t_match(1'b0);
    brd = 10'h3FF;
    send_frame(1'b0, 10'h3FF);
    idle(1'b0, 30);
    check(link == 2'b01, "R11 global-valued board address acts as disconnect", link, 1);
    check_no_ack("R11 no ack for global-valued board address");
    brd = 10'h2A5;
  endtask

  task automatic t_trst_mid;
    t_match(1'b0);
    @(negedge ck);
    #2 trst_n = 1'b0;
    #3;
    check(link == 2'b00, "R1 TRST returns to reset condition", link, 0);
    trst_n = 1'b1;
    idle(1'b1, 6);
  endtask

  initial begin
    t_reset();
    t_mismatch_tlr();
    step(1'b0, 0);
    t_match(1'b0);
    t_sync_rti();
    t_sync_pause();
    t_bypass();
    t_abort();
    go_pause_dr();
    t_shift();
    t_globals();
    t_global_board();
    t_trst_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule